// File: doc/BRIEF.md
# Six-Step Commutation Sequencer

This block turns a stream of step pulses from an external motor controller into the six gate-drive signals of a three-phase bridge used for block commutation. A three-bit twisted-ring counter advances once on each clock edge while the enable input is high. The counter's state is decoded so that in every legal state exactly one phase has its high side on and another phase has its low side on.

The two bit patterns that lie outside the six-state ring are handled inside the block. The next-state logic carries a correction term, so the counter returns to the ring within two steps. While it sits on an illegal pattern, all six drives are held off.

A PWM input chops the three high-side drives. A synchronous clear sends the counter back to the zero state. A parameter selects whether the physical drive levels are active-high or active-low.

Top module: `sixstep_seq`

## Requirements
- R1: While rst_n is low the counter takes the value INIT_STATE (default 000). With enable and PWM high and INIT_STATE = 000, the outputs then show phase B high and phase C low.
- R2: On each rising clock edge with en high and clr low, the state (written Q2Q1Q0) follows the ring 000, 100, 110, 111, 011, 001 and then returns to 000.
- R3: The drives follow the state as listed below. Bit 0 of each drive bus is phase A, bit 1 is phase B and bit 2 is phase C.
  - 000: B high, C low.
  - 100: A high, C low.
  - 110: A high, B low.
  - 111: C high, B low.
  - 011: C high, A low.
  - 001: B high, A low.
- R4: In a legal state with en and pwm high, exactly one high drive and exactly one low drive are asserted. No phase ever has its high and low drives asserted together.
- R5: In the illegal patterns 010 and 101, all six drives are inactive.
- R6: The illegal pattern 010 steps to 101, and 101 steps to 000. The counter therefore rejoins the ring within two enabled edges.
- R7: While en is low, the counter holds its state and all six drives are inactive.
- R8: clr is sampled on the clock edge and loads 000 on that edge. It takes priority over en.
- R9: When pwm is low, the three high drives are inactive. The low drives and the counter are not affected by pwm.
- R10: With ACTIVE_LOW = 1, every output is the inverse of the active-high output, so an inactive drive reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock from the controller |
| rst_n | input | 1 | Asynchronous reset, active low, loads INIT_STATE |
| en | input | 1 | Step qualifier and drive enable |
| clr | input | 1 | Synchronous clear to state 000 |
| pwm | input | 1 | Chopping signal for the high-side drives |
| hi_drv | output | 3 | High-side drives, bit 0 = A, bit 1 = B, bit 2 = C |
| lo_drv | output | 3 | Low-side drives, bit 0 = A, bit 1 = B, bit 2 = C |

## Verification
Three functions can act in the same cycle, and each pairing is provoked on purpose:
- Clear and enabled stepping. clr is raised while en is high on a state in the middle of the ring. The test passes if the next decoded state is 000 and not the ring successor.
- PWM chopping and stepping. pwm is held low across several enabled steps. The test passes if the low drive keeps walking through its sequence while every high drive stays off.
- Illegal-pattern blanking and recovery. Separate instances start on 010 and on 101 and are stepped. The test passes if the outputs are all off on each illegal pattern and if the 000 drive pair appears on the expected edge.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
   localparam int PH_N = 3;
   localparam int ST_W = 3;
   typedef logic [ST_W-1:0] jstate_t;
   localparam jstate_t ST_HOME = '0;

   // twisted-ring step with a correction term on bit 1
   function automatic jstate_t jc_next(input jstate_t q);
      jstate_t n;
      n[0] = q[1];
      n[2] = ~q[0];
      n[1] = q[2] & (~q[0] | q[1]);
      return n;
   endfunction

   function automatic logic jc_legal(input jstate_t q);
      return (q != 3'b010) && (q != 3'b101);
   endfunction
endpackage

// File: rtl/sixstep_ring.sv
module sixstep_ring
   import sixstep_pkg::*;
#(
   parameter jstate_t INIT_STATE = ST_HOME
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en,
   input  logic    clr,
   output jstate_t state
);
   jstate_t nxt;

   always_comb begin
      if (clr)     nxt = ST_HOME;
      else if (en) nxt = jc_next(state);
      else         nxt = state;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= INIT_STATE;
      else        state <= nxt;
   end

   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (state == ST_HOME));
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> $stable(state));
   a_r6_from_010: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && en && state == 3'b010) |=> (state == 3'b101));
   a_r6_from_101: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && en && state == 3'b101) |=> (state == ST_HOME));
endmodule

// File: rtl/sixstep_decode.sv
module sixstep_decode
   import sixstep_pkg::*;
(
   input  jstate_t         state,
   input  logic            en,
   input  logic            pwm,
   output logic [PH_N-1:0] hi_on,
   output logic [PH_N-1:0] lo_on
);
   logic [PH_N-1:0] hi_raw, lo_raw;
   logic            gate;

   always_comb begin
      hi_raw = '0;
      lo_raw = '0;
      unique case (state)
         3'b000: begin hi_raw[1] = 1'b1; lo_raw[2] = 1'b1; end
         3'b100: begin hi_raw[0] = 1'b1; lo_raw[2] = 1'b1; end
         3'b110: begin hi_raw[0] = 1'b1; lo_raw[1] = 1'b1; end
         3'b111: begin hi_raw[2] = 1'b1; lo_raw[1] = 1'b1; end
         3'b011: begin hi_raw[2] = 1'b1; lo_raw[0] = 1'b1; end
         3'b001: begin hi_raw[1] = 1'b1; lo_raw[0] = 1'b1; end
         default: begin hi_raw = '0; lo_raw = '0; end
      endcase
   end

   assign gate  = en & jc_legal(state);
   assign hi_on = hi_raw & {PH_N{gate & pwm}};
   assign lo_on = lo_raw & {PH_N{gate}};
endmodule

// File: rtl/sixstep_pad.sv
module sixstep_pad #(
   parameter int W          = 3,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic [W-1:0] on,
   output logic [W-1:0] pin
);
   generate
      if (ACTIVE_LOW) begin : g_low
         assign pin = ~on;
      end else begin : g_high
         assign pin = on;
      end
   endgenerate
endmodule

// File: rtl/sixstep_seq.sv
module sixstep_seq
   import sixstep_pkg::*;
#(
   parameter bit      ACTIVE_LOW = 1'b0,
   parameter jstate_t INIT_STATE = ST_HOME
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            clr,
   input  logic            pwm,
   output logic [PH_N-1:0] hi_drv,
   output logic [PH_N-1:0] lo_drv
);
   generate
      if (PH_N != 3) begin : g_bad_phases
         $error("sixstep_seq supports three phases only");
      end
   endgenerate

   jstate_t         state;
   logic [PH_N-1:0] hi_on, lo_on;

   sixstep_ring #(.INIT_STATE(INIT_STATE)) u_ring (
      .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .state(state)
   );

   sixstep_decode u_dec (
      .state(state), .en(en), .pwm(pwm), .hi_on(hi_on), .lo_on(lo_on)
   );

   sixstep_pad #(.W(PH_N), .ACTIVE_LOW(ACTIVE_LOW)) u_pad_hi (
      .on(hi_on), .pin(hi_drv)
   );
   sixstep_pad #(.W(PH_N), .ACTIVE_LOW(ACTIVE_LOW)) u_pad_lo (
      .on(lo_on), .pin(lo_drv)
   );

   a_r4_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_on & lo_on) == '0);
   a_r4_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pwm && jc_legal(state)) |->
         ($countones(hi_on) == 1 && $countones(lo_on) == 1));
   a_r5_illegal_off: assert property (@(posedge clk) disable iff (!rst_n)
      !jc_legal(state) |-> (hi_on == '0 && lo_on == '0));
   a_r9_chop: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm |-> (hi_on == '0));
   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (hi_on == '0 && lo_on == '0));
endmodule

// File: tb/sixstep_seq_tb.sv
module sixstep_seq_tb;
   localparam time TCLK = 10ns;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, clr = 1'b0, pwm = 1'b1;
   logic [2:0] hi_a, lo_a, hi_n, lo_n, hi_x, lo_x, hi_y, lo_y;
   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #(TCLK/2) clk = ~clk;

   sixstep_seq u_dut (.clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .pwm(pwm),
                      .hi_drv(hi_a), .lo_drv(lo_a));
   sixstep_seq #(.ACTIVE_LOW(1'b1)) u_inv (.clk(clk), .rst_n(rst_n), .en(en),
                      .clr(clr), .pwm(pwm), .hi_drv(hi_n), .lo_drv(lo_n));
   sixstep_seq #(.INIT_STATE(3'b010)) u_ill0 (.clk(clk), .rst_n(rst_n), .en(en),
                      .clr(clr), .pwm(pwm), .hi_drv(hi_x), .lo_drv(lo_x));
   sixstep_seq #(.INIT_STATE(3'b101)) u_ill1 (.clk(clk), .rst_n(rst_n), .en(en),
                      .clr(clr), .pwm(pwm), .hi_drv(hi_y), .lo_drv(lo_y));

   // ring position k: expected high and low one-hot drives
   function automatic logic [2:0] exp_hi(input int k);
      case (k % 6)
         0: return 3'b010; 1: return 3'b001; 2: return 3'b001;
         3: return 3'b100; 4: return 3'b100; default: return 3'b010;
      endcase
   endfunction
   function automatic logic [2:0] exp_lo(input int k);
      case (k % 6)
         0: return 3'b100; 1: return 3'b100; 2: return 3'b010;
         3: return 3'b010; 4: return 3'b001; default: return 3'b001;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [5:0] act,
                      input logic [5:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
      end
   endtask

   task automatic chk_pair(input string req, input logic [2:0] eh, input logic [2:0] el);
      chk({hi_a, lo_a} == {eh, el}, req, {hi_a, lo_a}, {eh, el});
      chk((hi_a & lo_a) == 3'b000, "R4 no phase both", {hi_a, lo_a}, {eh, el});
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; en = 1'b0; clr = 1'b0; pwm = 1'b1;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk({hi_a, lo_a} == 6'b0, "R7 en low drives off", {hi_a, lo_a}, 6'b0);
      en = 1'b1;
      #1 chk_pair("R1 reset state 000", 3'b010, 3'b100);
   endtask

   task automatic t_ring();
      // en is high; state is at position 0
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         chk_pair("R2 R3 ring order", exp_hi(k), exp_lo(k));
         chk($countones(hi_a) == 1 && $countones(lo_a) == 1, "R4 one pair",
             {hi_a, lo_a}, {exp_hi(k), exp_lo(k)});
      end
   endtask

   task automatic t_polarity();
      do_reset(); en = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk({hi_n, lo_n} == ~{hi_a, lo_a}, "R10 active low", {hi_n, lo_n}, ~{hi_a, lo_a});
      end
      en = 1'b0; #1;
      chk({hi_n, lo_n} == 6'b111111, "R10 inactive reads 1", {hi_n, lo_n}, 6'b111111);
   endtask

   task automatic t_enable();
      do_reset(); en = 1'b1;
      @(negedge clk); @(negedge clk);   // position 2
      en = 1'b0;
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk({hi_a, lo_a} == 6'b0, "R7 drives off", {hi_a, lo_a}, 6'b0);
      en = 1'b1; #1;
      chk_pair("R7 state held", exp_hi(2), exp_lo(2));
   endtask

   task automatic t_clear();
      do_reset(); en = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);   // position 3
      clr = 1'b1;
      @(negedge clk); clr = 1'b0; #1;
      chk_pair("R8 clear beats enable", exp_hi(0), exp_lo(0));
      @(negedge clk);
      chk_pair("R8 ring resumes", exp_hi(1), exp_lo(1));
   endtask

   task automatic t_pwm();
      do_reset(); en = 1'b1; pwm = 1'b0; #1;
      for (int k = 0; k < 6; k++) begin
         chk({hi_a, lo_a} == {3'b000, exp_lo(k)}, "R9 pwm chops high only",
             {hi_a, lo_a}, {3'b000, exp_lo(k)});
         @(negedge clk);
      end
      pwm = 1'b1; #1;
      chk_pair("R9 counter unaffected", exp_hi(6), exp_lo(6));
   endtask

   task automatic t_illegal();
      do_reset(); en = 1'b1; #1;
      chk({hi_x, lo_x} == 6'b0, "R5 010 drives off", {hi_x, lo_x}, 6'b0);
      chk({hi_y, lo_y} == 6'b0, "R5 101 drives off", {hi_y, lo_y}, 6'b0);
      @(negedge clk);
      chk({hi_x, lo_x} == 6'b0, "R6 010 to 101 off", {hi_x, lo_x}, 6'b0);
      chk({hi_y, lo_y} == {exp_hi(0), exp_lo(0)}, "R6 101 to 000",
          {hi_y, lo_y}, {exp_hi(0), exp_lo(0)});
      @(negedge clk);
      chk({hi_x, lo_x} == {exp_hi(0), exp_lo(0)}, "R6 010 rejoins in two",
          {hi_x, lo_x}, {exp_hi(0), exp_lo(0)});
      chk({hi_y, lo_y} == {exp_hi(1), exp_lo(1)}, "R6 101 continues ring",
          {hi_y, lo_y}, {exp_hi(1), exp_lo(1)});
   endtask

   initial begin
      #(TCLK * 20000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_ring();
      t_polarity();
      t_enable();
      t_clear();
      t_pwm();
      t_illegal();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule